// File: doc/BRIEF.md
# Colour LCD Controller Register and Interrupt Block

This block is the memory-mapped register slave of a colour LCD controller. A host reaches it through a 4 KB window of word registers. The window holds four panel timing words, the upper and lower frame base addresses, a control word, an interrupt mask, raw and masked status, a write-one-to-clear register and a read-only identification area. The block decodes the active frame size, pixel depth and ordering flags from those words. It drives a display-enable qualifier to the pixel pipeline and a level interrupt to the system.

A per-frame vertical-blank strobe from the timing generator raises two status events, but only while the display is enabled. A two-bit variant strap selects the identification table. On every variant except the base one, the strap also swaps the word offsets of the mask and control registers. Reads are registered: data appears one cycle after the read request.

Top module: `lcdc_regs`

## Requirements
- R1: A synchronous active-high reset clears every register. After reset `display_en` and `irq` are 0, `cols` is 16 and `rows` is 1.
- R2: The column count is 16 × (timing word 0 bits [7:2] + 1). The row count is timing word 1 bits [9:0] + 1. Other bits of those words are stored and read back, but they do not affect the counts.
- R3: Control bits [3:1] drive `bpp_mode`. Bit 8 drives `bgr_order`, bit 9 drives `byte_big_endian` and bit 10 drives `pixel_big_endian`.
- R4: `display_en` is 1 only when control bit 0 (enable) and bit 11 (power) are both 1.
- R5: `irq` is 1 whenever raw status AND mask (bits [4:0]) is non-zero. Byte offset 0x20 reads the raw status and 0x24 reads the masked status. The mask reads back its bits [4:0], and the upper bits read as 0.
- R6: A write to byte offset 0x28 clears each raw status bit written as 1.
- R7: A vertical-blank strobe while enabled sets status bit 2 and bit 3. If a clear arrives in the same cycle, the set wins.
- R8: A vertical-blank strobe while the display is disabled has no effect.
- R9: When `variant` is 0, offset 0x18 is the mask and 0x1C is the control word. For any other `variant` value, the two offsets are swapped for both reads and writes.
- R10: Offsets 0xFE0 to 0xFFC each return one identification byte. The sequence is 10 11 04 00 0D F0 05 B1 when `variant` is 0 or 1, and 11 11 24 00 0D F0 05 B1 when `variant` is 2 or 3.
- R11: Offsets 0x2C and 0x30 return the upper and lower base words (0x10 and 0x14). Unknown offsets read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| variant | input | 2 | Variant strap: offset swap and identification table |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read request; data appears next cycle |
| addr | input | 12 | Byte address in the window (bits [1:0] ignored) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| vblank_strobe | input | 1 | One-cycle vertical-blank pulse |
| irq | output | 1 | Level interrupt |
| display_en | output | 1 | Enable and power both set |
| cols | output | 11 | Active column count |
| rows | output | 11 | Active row count |
| bpp_mode | output | 3 | Bits-per-pixel code |
| bgr_order | output | 1 | BGR colour ordering |
| byte_big_endian | output | 1 | Big-endian byte order |
| pixel_big_endian | output | 1 | Big-endian pixel order within a byte |

## Verification
A write or a strobe is committed at one clock edge. The decoded outputs (`cols`, `rows`, `bpp_mode`, flags, `display_en`) and `irq` then show the new value after that same edge, because they are combinational on the registers. Read data takes one more register, so it is due one edge after the read request. The bench drives every input on a falling edge and samples on the next falling edge. That puts each write result half a cycle after the edge that commits it, and each read result half a cycle after the edge that latches it.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    parameter int DW     = 32;
    parameter int STAT_W = 5;

    localparam int CTL_EN    = 0;
    localparam int CTL_BPP_LO = 1;
    localparam int CTL_BGR   = 8;
    localparam int CTL_BEB   = 9;
    localparam int CTL_BEP   = 10;
    localparam int CTL_PWR   = 11;

    localparam logic [STAT_W-1:0] VBLANK_BITS = STAT_W'(5'b01100);

    typedef enum logic [3:0] {
        SEL_T0, SEL_T1, SEL_T2, SEL_T3,
        SEL_UPB, SEL_LPB, SEL_MASK, SEL_CTRL,
        SEL_RIS, SEL_MIS, SEL_ICR, SEL_UPCUR,
        SEL_LPCUR, SEL_ID, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [STAT_W-1:0] raw;
        logic [STAT_W-1:0] mask;
    } irq_state_t;

    typedef struct packed {
        logic [3:0][DW-1:0] timing;
        logic [DW-1:0]      upbase;
        logic [DW-1:0]      lpbase;
        logic [DW-1:0]      ctrl;
        logic [DW-1:0]      rdata;
    } reg_state_t;

    function automatic logic [7:0] id_byte(input logic [1:0] variant, input logic [2:0] idx);
        logic ext;
        ext = variant[1];
        case (idx)
            3'd0:    id_byte = ext ? 8'h11 : 8'h10;
            3'd1:    id_byte = 8'h11;
            3'd2:    id_byte = ext ? 8'h24 : 8'h04;
            3'd3:    id_byte = 8'h00;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              swap,
    output reg_sel_e          sel,
    output logic [2:0]        id_idx
);
    localparam int WORD_W  = ADDR_W - 2;
    localparam int ID_BASE = (1 << WORD_W) - 8;

    logic [WORD_W-1:0] word;
    int unsigned       w;

    assign word   = addr[ADDR_W-1:2];
    assign w      = 32'(word);
    assign id_idx = word[2:0];

    always_comb begin
        if (w >= ID_BASE) begin
            sel = SEL_ID;
        end else begin
            case (w)
                0:       sel = SEL_T0;
                1:       sel = SEL_T1;
                2:       sel = SEL_T2;
                3:       sel = SEL_T3;
                4:       sel = SEL_UPB;
                5:       sel = SEL_LPB;
                6:       sel = swap ? SEL_CTRL : SEL_MASK;
                7:       sel = swap ? SEL_MASK : SEL_CTRL;
                8:       sel = SEL_RIS;
                9:       sel = SEL_MIS;
                10:      sel = SEL_ICR;
                11:      sel = SEL_UPCUR;
                12:      sel = SEL_LPCUR;
                default: sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/lcdc_irq_ctrl.sv
module lcdc_irq_ctrl
    import lcdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [DW-1:0]     wdata,
    input  logic              vblank_set,
    output logic [STAT_W-1:0] raw,
    output logic [STAT_W-1:0] mask,
    output logic              irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = wdata[STAT_W-1:0];
        if (clr_we)  st_d.raw  = st_q.raw & ~wdata[STAT_W-1:0];
        if (vblank_set) st_d.raw = st_d.raw | VBLANK_BITS;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign raw  = st_q.raw;
    assign mask = st_q.mask;
    assign irq  = |(st_q.raw & st_q.mask);

    // R7: a strobe always leaves both frame events set, clear or not
    a_r7_vblank_sets: assert property (@(posedge clk) disable iff (rst)
        vblank_set |=> (raw[3:2] == 2'b11));

    // R6: bits written as 1 to the clear register are gone next cycle
    a_r6_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !vblank_set) |=> ((raw & $past(wdata[STAT_W-1:0])) == '0));

    // R5: without set, clear or mask write, the interrupt level holds
    a_r5_irq_holds: assert property (@(posedge clk) disable iff (rst)
        (!vblank_set && !clr_we && !mask_we) |=> $stable(irq));
endmodule

// File: rtl/lcdc_geom.sv
module lcdc_geom
    import lcdc_pkg::*;
#(
    parameter int DIM_W = 11
) (
    input  logic [DW-1:0]    timing0,
    input  logic [DW-1:0]    timing1,
    input  logic [DW-1:0]    ctrl,
    output logic [DIM_W-1:0] cols,
    output logic [DIM_W-1:0] rows,
    output logic [2:0]       bpp_mode,
    output logic             bgr_order,
    output logic             byte_big_endian,
    output logic             pixel_big_endian,
    output logic             display_en
);
    logic [5:0] ppl_field;
    logic [9:0] lpp_field;

    assign ppl_field = timing0[7:2];
    assign lpp_field = timing1[9:0];

    assign cols = DIM_W'((32'(ppl_field) + 32'd1) * 32'd16);
    assign rows = DIM_W'(32'(lpp_field) + 32'd1);

    assign bpp_mode         = ctrl[CTL_BPP_LO +: 3];
    assign bgr_order        = ctrl[CTL_BGR];
    assign byte_big_endian  = ctrl[CTL_BEB];
    assign pixel_big_endian = ctrl[CTL_BEP];
    assign display_en       = ctrl[CTL_EN] & ctrl[CTL_PWR];
endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
    import lcdc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DIM_W  = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        variant,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    input  logic              vblank_strobe,
    output logic              irq,
    output logic              display_en,
    output logic [DIM_W-1:0]  cols,
    output logic [DIM_W-1:0]  rows,
    output logic [2:0]        bpp_mode,
    output logic              bgr_order,
    output logic              byte_big_endian,
    output logic              pixel_big_endian
);
    reg_state_t        r_d, r_q;
    reg_sel_e          sel;
    logic [2:0]        id_idx;
    logic [STAT_W-1:0] raw, mask;
    logic              mask_we, clr_we, vblank_set;

    lcdc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .swap   (variant != 2'd0),
        .sel    (sel),
        .id_idx (id_idx)
    );

    assign mask_we    = wr_en && (sel == SEL_MASK);
    assign clr_we     = wr_en && (sel == SEL_ICR);
    assign vblank_set = vblank_strobe && display_en;

    lcdc_irq_ctrl u_irq (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (mask_we),
        .clr_we     (clr_we),
        .wdata      (wr_data),
        .vblank_set (vblank_set),
        .raw        (raw),
        .mask       (mask),
        .irq        (irq)
    );

    lcdc_geom #(.DIM_W(DIM_W)) u_geom (
        .timing0          (r_q.timing[0]),
        .timing1          (r_q.timing[1]),
        .ctrl             (r_q.ctrl),
        .cols             (cols),
        .rows             (rows),
        .bpp_mode         (bpp_mode),
        .bgr_order        (bgr_order),
        .byte_big_endian  (byte_big_endian),
        .pixel_big_endian (pixel_big_endian),
        .display_en       (display_en)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (sel)
                SEL_T0:   r_d.timing[0] = wr_data;
                SEL_T1:   r_d.timing[1] = wr_data;
                SEL_T2:   r_d.timing[2] = wr_data;
                SEL_T3:   r_d.timing[3] = wr_data;
                SEL_UPB:  r_d.upbase    = wr_data;
                SEL_LPB:  r_d.lpbase    = wr_data;
                SEL_CTRL: r_d.ctrl      = wr_data;
                default:  ;
            endcase
        end
        if (rd_en) begin
            case (sel)
                SEL_T0:    r_d.rdata = r_q.timing[0];
                SEL_T1:    r_d.rdata = r_q.timing[1];
                SEL_T2:    r_d.rdata = r_q.timing[2];
                SEL_T3:    r_d.rdata = r_q.timing[3];
                SEL_UPB,
                SEL_UPCUR: r_d.rdata = r_q.upbase;
                SEL_LPB,
                SEL_LPCUR: r_d.rdata = r_q.lpbase;
                SEL_CTRL:  r_d.rdata = r_q.ctrl;
                SEL_MASK:  r_d.rdata = DW'(mask);
                SEL_RIS:   r_d.rdata = DW'(raw);
                SEL_MIS:   r_d.rdata = DW'(raw & mask);
                SEL_ID:    r_d.rdata = DW'(id_byte(variant, id_idx));
                default:   r_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rd_data = r_q.rdata;

    // R2: a row-count write takes effect on the next cycle
    a_r2_rows_follow: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_T1) |=> (rows == DIM_W'(32'($past(wr_data[9:0])) + 32'd1)));

    // R8: a strobe while disabled leaves the interrupt unchanged
    a_r8_vblank_ignored: assert property (@(posedge clk) disable iff (rst)
        (vblank_strobe && !display_en && !wr_en) |=> $stable(irq));

    // R11: reads of unknown offsets return zero
    a_r11_unknown_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_NONE) |=> (rd_data == '0));

    // R4: the enable qualifier can only change on a write
    a_r4_en_write_only: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(display_en));
endmodule

// File: tb/lcdc_regs_tb.sv
module lcdc_regs_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  variant = 2'd0;
    logic        wr_en = 1'b0, rd_en = 1'b0, vblank_strobe = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq, display_en, bgr_order, byte_big_endian, pixel_big_endian;
    logic [10:0] cols, rows;
    logic [2:0]  bpp_mode;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lcdc_regs u_dut (
        .clk(clk), .rst(rst), .variant(variant), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .vblank_strobe(vblank_strobe), .irq(irq), .display_en(display_en),
        .cols(cols), .rows(rows), .bpp_mode(bpp_mode), .bgr_order(bgr_order),
        .byte_big_endian(byte_big_endian), .pixel_big_endian(pixel_big_endian)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] v);
        @(negedge clk);
        variant = v;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic strobe(input logic with_clear, input logic [31:0] clr);
        @(negedge clk);
        vblank_strobe = 1'b1;
        if (with_clear) begin addr = 12'h028; wr_data = clr; wr_en = 1'b1; end
        @(negedge clk);
        vblank_strobe = 1'b0; wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset(2'd0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 display_en", 32'(display_en), 0);
        chk("R1 cols", 32'(cols), 16);
        chk("R1 rows", 32'(rows), 1);
        rd(12'h01C, d); chk("R1 ctrl read", d, 0);
    endtask

    task automatic t_geometry();
        logic [31:0] d;
        wr(12'h000, 32'h0000_00FC); chk("R2 cols max", 32'(cols), 1024);
        wr(12'h000, 32'hABCD_0028); chk("R2 cols 176", 32'(cols), 176);
        rd(12'h000, d); chk("R2 timing0 readback", d, 32'hABCD_0028);
        wr(12'h004, 32'h0000_03FF); chk("R2 rows max", 32'(rows), 1024);
        wr(12'h004, 32'hFFFF_FCEF); chk("R2 rows upper ignored", 32'(rows), 240);
        wr(12'h00C, 32'h1234_5678);
        rd(12'h00C, d); chk("R2 timing3 readback", d, 32'h1234_5678);
    endtask

    task automatic t_control();
        wr(12'h01C, 32'h0000_0F0B);
        chk("R3 bpp", 32'(bpp_mode), 5);
        chk("R3 flags", {29'd0, bgr_order, byte_big_endian, pixel_big_endian}, 32'h7);
        chk("R4 enabled", 32'(display_en), 1);
        wr(12'h01C, 32'h0000_0701);
        chk("R4 power off", 32'(display_en), 0);
        wr(12'h01C, 32'h0000_0800);
        chk("R4 enable off", 32'(display_en), 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(12'h01C, 32'h0000_0801);
        wr(12'h018, 32'hFFFF_FF08);
        rd(12'h018, d); chk("R5 mask readback", d, 32'h08);
        strobe(1'b0, 0);
        chk("R7 irq raised", 32'(irq), 1);
        rd(12'h020, d); chk("R7 raw", d, 32'h0C);
        rd(12'h024, d); chk("R5 masked", d, 32'h08);
        wr(12'h028, 32'h0000_0008);
        chk("R6 irq after clear", 32'(irq), 0);
        rd(12'h020, d); chk("R6 raw after clear", d, 32'h04);
        wr(12'h018, 32'h0000_0004);
        chk("R5 irq on new mask", 32'(irq), 1);
        wr(12'h028, 32'hFFFF_FFFF);
        chk("R6 clear all", 32'(irq), 0);
        strobe(1'b1, 32'h0000_000C);
        rd(12'h020, d); chk("R7 set beats clear", d, 32'h0C);
        wr(12'h028, 32'h0000_000C);
        wr(12'h01C, 32'h0000_0001);
        strobe(1'b0, 0);
        chk("R8 irq stays low", 32'(irq), 0);
        rd(12'h020, d); chk("R8 raw untouched", d, 0);
    endtask

    task automatic t_swap();
        logic [31:0] d;
        do_reset(2'd1);
        wr(12'h018, 32'h0000_0801);
        chk("R9 offset 0x18 is control", 32'(display_en), 1);
        wr(12'h01C, 32'h0000_0008);
        rd(12'h01C, d); chk("R9 offset 0x1C is mask", d, 32'h08);
        rd(12'h018, d); chk("R9 control readback", d, 32'h0801);
        strobe(1'b0, 0);
        chk("R9 irq via swapped mask", 32'(irq), 1);
    endtask

    task automatic t_id();
        logic [31:0] d;
        rd(12'hFE0, d); chk("R10 v1 id0", d, 32'h10);
        rd(12'hFE8, d); chk("R10 v1 id2", d, 32'h04);
        do_reset(2'd2);
        rd(12'hFE0, d); chk("R10 v2 id0", d, 32'h11);
        rd(12'hFE8, d); chk("R10 v2 id2", d, 32'h24);
        rd(12'hFF4, d); chk("R10 v2 id5", d, 32'hF0);
        rd(12'hFFC, d); chk("R10 v2 id7", d, 32'hB1);
        do_reset(2'd0);
        rd(12'hFE4, d); chk("R10 v0 id1", d, 32'h11);
        rd(12'hFF0, d); chk("R10 v0 id4", d, 32'h0D);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        wr(12'h010, 32'h8000_1000);
        wr(12'h014, 32'h8004_0000);
        rd(12'h02C, d); chk("R11 upper current", d, 32'h8000_1000);
        rd(12'h030, d); chk("R11 lower current", d, 32'h8004_0000);
        wr(12'h200, 32'hDEAD_BEEF);
        rd(12'h200, d); chk("R11 unknown reads 0", d, 0);
        wr(12'h034, 32'h0000_0801);
        chk("R11 unknown write ignored", 32'(display_en), 0);
        rd(12'h01C, d); chk("R11 control untouched", d, 0);
    endtask

    initial begin
        t_reset();
        t_geometry();
        t_control();
        t_irq();
        t_swap();
        t_id();
        t_misc();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule